// File: doc/BRIEF.md
# Skid-Buffered Handshake Stage

This block is one register stage of a pipeline whose stages talk through a valid/ready handshake. In a pipeline with no spare storage, a stall at the far end must reach every earlier stage within one cycle. Here the stage keeps one spare holding register beside its output register. In the first cycle of a downstream stall it parks the item that was in flight into the spare register. It then withdraws its own ready on the following clock edge. The ready seen by the upstream side therefore comes straight from a flip-flop and never passes combinationally through this stage from the downstream side.

An output mux feeds the output register from either the incoming data or the spare register. When the downstream side resumes, the parked item is sent first, so the order of items is kept. The stage performs no computation on the data. The reset input is asynchronous, active low, and is expected to be deasserted in step with the clock.

Top module: `skid_stage`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: An item is accepted on a clock edge where `in_valid` and `in_ready` are both 1. If the output register is empty or `out_ready` is 1 at that edge, the item appears on `out_data` with `out_valid` = 1 after that edge.
- R3: If `out_valid` is 1 and `out_ready` is 0 at a clock edge, then `out_valid` stays 1 and `out_data` stays unchanged after that edge.
- R4: An item accepted while the output is stalled is parked in the spare register. After that edge `in_ready` is 0.
- R5: `in_ready` is 0 exactly when the spare register holds an item. It is a register output, so it changes only at clock edges. Whenever it is 0, `out_valid` is 1.
- R6: When a stalled output is taken (`out_ready` = 1) while an item is parked, the parked item is presented next, ahead of any newer item. `in_ready` returns to 1 after that same edge.
- R7: Under any pattern of `in_valid` and `out_ready`, every accepted item leaves exactly once, and items leave in the order they were accepted.
- R8: An item offered while `in_ready` is 0 is not accepted, and it never appears on the output.
- R9: If the output is taken, nothing is parked and no item is accepted, `out_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream offers an item |
| in_data | input | DATA_W | Upstream item |
| in_ready | output | 1 | Registered: stage can take an item this cycle |
| out_valid | output | 1 | Output register holds an item |
| out_data | output | DATA_W | Item presented downstream |
| out_ready | input | 1 | Downstream takes the presented item |

## Verification
The bench targets the cycle where a stall begins while an item is being offered. A design that failed to park that item would lose it, and one that withdrew ready a cycle late would overwrite the spare register. The bench also targets the release of a stall with an item parked. Here a wrong mux select would send the newer item first or repeat the older one, and the bench sees this as a reordered or duplicated value. Offers made while ready is low are given distinctive values, so a design that accepted them would show those values on the output. Long random runs mix stall densities so that the spare register fills and drains back to back.

// File: rtl/skid_pkg.sv
package skid_pkg;

  // Source selected for the output register.
  typedef enum logic {
    SRC_DIRECT = 1'b0,
    SRC_SPARE  = 1'b1
  } skid_src_e;

  // Load controls sent from the control unit to the datapath.
  typedef struct packed {
    logic      main_en;
    logic      spare_en;
    skid_src_e src;
  } skid_ctl_t;

endpackage

// File: rtl/skid_ctrl.sv
module skid_ctrl
  import skid_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic      out_ready,
  output logic      in_ready,
  output logic      out_valid,
  output skid_ctl_t ctl
);

  logic full_q, full_n;
  logic vld_q, vld_n;
  logic rdy_q, rdy_n;
  logic take_in;
  logic main_free;

  // The output register can load when it is empty or being emptied.
  assign main_free = out_ready | ~vld_q;
  assign take_in   = in_valid & rdy_q;

  always_comb begin
    full_n = full_q;
    vld_n  = vld_q;
    ctl.main_en  = 1'b0;
    ctl.spare_en = 1'b0;
    ctl.src      = SRC_DIRECT;
    if (main_free) begin
      // A parked item always moves ahead of anything new.
      if (full_q) begin
        ctl.main_en = 1'b1;
        ctl.src     = SRC_SPARE;
        full_n      = 1'b0;
        vld_n       = 1'b1;
      end else if (take_in) begin
        ctl.main_en = 1'b1;
        vld_n       = 1'b1;
      end else begin
        vld_n       = 1'b0;
      end
    end else if (take_in) begin
      // Output is stalled: park the in-flight item.
      ctl.spare_en = 1'b1;
      full_n       = 1'b1;
    end
    rdy_n = ~full_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      vld_q  <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      full_q <= full_n;
      vld_q  <= vld_n;
      rdy_q  <= rdy_n;
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = vld_q;

endmodule

// File: rtl/skid_datapath.sv
module skid_datapath
  import skid_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  skid_ctl_t         ctl,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] spare_q, spare_n;
  logic [DATA_W-1:0] main_q, main_n;
  logic [DATA_W-1:0] mux_o;

  assign mux_o = (ctl.src == SRC_SPARE) ? spare_q : in_data;

  always_comb begin
    spare_n = ctl.spare_en ? in_data : spare_q;
    main_n  = ctl.main_en  ? mux_o   : main_q;
  end

  // Data registers carry no reset; the valid and full flags qualify them.
  always_ff @(posedge clk) begin
    spare_q <= spare_n;
    main_q  <= main_n;
  end

  assign out_data = main_q;

endmodule

// File: rtl/skid_stage.sv
module skid_stage
  import skid_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);

  skid_ctl_t ctl;

  skid_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .ctl       (ctl)
  );

  skid_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .ctl      (ctl),
    .in_data  (in_data),
    .out_data (out_data)
  );

endmodule

// File: rtl/skid_stage_checker.sv
module skid_stage_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready
);

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (!out_valid || out_ready)) |=> (out_valid && out_data == $past(in_data))); // R2

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R3

  AST_READY_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && out_valid && !out_ready)); // R4

  AST_PARK_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid); // R5

  AST_READY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(out_valid && out_ready)); // R6

  AST_EMPTY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_ready && !in_valid) |=> !out_valid); // R9

endmodule

bind skid_stage skid_stage_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/skid_stage_bench.sv
`timescale 1ns/1ps
module skid_stage_bench;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_ready;

  int n_chk;
  int n_bad;
  bit done;

  // Behavioural reference: queue of items held by the stage, plus ready.
  logic [W-1:0] mq[$];
  bit           mrdy;
  int           n_acc;
  int           n_del;

  skid_stage #(.DATA_W(W)) u_skid_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare all outputs against the reference state.
  task automatic compare_model();
    check("R2 out_valid", int'(out_valid), int'(mq.size() > 0));
    check("R5 in_ready", int'(in_ready), int'(mrdy));
    if (mq.size() > 0 && out_valid) check("R7 out_data", int'(out_data), int'(mq[0]));
  endtask

  // Drive inputs for one edge, advance the reference, then compare.
  task automatic step(input bit vu, input logic [W-1:0] du, input bit rd);
    bit pop, push;
    in_valid  = vu;
    in_data   = du;
    out_ready = rd;
    pop  = (mq.size() > 0) && rd;
    push = vu && mrdy;
    if (pop) begin
      void'(mq.pop_front());
      n_del++;
    end
    if (push) begin
      mq.push_back(du);
      n_acc++;
    end
    mrdy = (mq.size() < 2);
    @(negedge clk);
    compare_model();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0; n_acc = 0; n_del = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    mrdy = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", int'(out_valid), 0);
    check("R1 in_ready after release", int'(in_ready), 1);

    // Directed stall and release sequence.
    step(1'b1, 8'h11, 1'b1);
    check("R2 first item", int'(out_data), 'h11);
    step(1'b1, 8'h22, 1'b0);
    check("R3 held data", int'(out_data), 'h11);
    check("R4 ready drops after park", int'(in_ready), 0);
    step(1'b1, 8'h33, 1'b0);
    check("R8 offer ignored, data held", int'(out_data), 'h11);
    step(1'b1, 8'h44, 1'b1);
    check("R6 parked item next", int'(out_data), 'h22);
    check("R6 ready back", int'(in_ready), 1);
    check("R8 rejected item absent", int'(out_data != 8'h33 && out_data != 8'h44), 1);
    step(1'b0, 8'h00, 1'b1);
    check("R9 valid falls", int'(out_valid), 0);

    // Random traffic at several stall and offer densities.
    for (int ph = 0; ph < 6; ph++) begin
      for (int c = 0; c < 500; c++) begin
        bit vu, rd;
        vu = ($urandom_range(0, 9) < (ph % 3) * 3 + 3);
        rd = ($urandom_range(0, 9) < ((ph + 1) % 3) * 3 + 2);
        step(vu, W'($urandom), rd);
      end
    end

    // Drain.
    repeat (4) step(1'b0, 8'h00, 1'b1);
    check("R7 stage empty after drain", int'(out_valid), 0);
    check("R7 delivered equals accepted", n_del, n_acc);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule